// File: doc/BRIEF.md
# Time-Slotted Audio Link Frame Receiver

This block is the receiving half of a serial audio link. The link carries a fixed frame of 256 bits. With the nominal 12.288 MHz bit clock this gives a 48 kHz frame rate. The block samples the frame-sync line and the serial data line on every falling edge of the bit clock. It finds the start of each frame and splits the bit stream into parallel fields.

A frame opens with a 16-bit tag. The first tag bit says whether the frame holds any valid data. The next twelve bits say which of the twelve slots carry valid data, and the last three tag bits are ignored. Twelve 20-bit slots follow the tag. In order they are the command address, the command data, and then the PCM slots.

Each slot is passed on in two ways. When the slot completes, it appears on a one-cycle strobe together with its number, its payload and its valid flag. It is also copied into a bank that holds the latest payload of every slot. A frame-done strobe marks the end of slot 12. An error strobe reports frame sync that comes too early or does not come at all. After either fault the block realigns to the next sync rising edge.

Top module: `slotlink_frame_rx`

## Requirements
- R1: When rst_n is low at a falling bit-clock edge, every output is cleared. After reset the block hunts for a frame start, and gives no slot strobe, no frame_done and no sync_err until one is found.
- R2: A frame starts only at a falling edge where sync_in is 1 and was 0 at the previous falling edge. If sync_in is held high out of reset, no frame starts.
- R3: The 16 bits sampled on the 16 falling edges after the start edge form the tag. The first of these bits is the frame-valid bit, the next twelve are the flags for slots 1 to 12 in that order, and the last three are ignored. After the edge that samples the sixteenth tag bit, frame_valid and slot_tag show the tag, with slot_tag bit k-1 for slot k. They hold these values through the rest of the frame.
- R4: Twelve 20-bit slots follow the tag, each sent MSB first. After the edge that samples the last bit of a slot, slot_stb is high for one bit clock. In that cycle slot_num shows the slot number, 1 to 12 in ascending order, and slot_data shows the payload.
- R5: When the frame-valid bit is 0, slot_tag is all zero and slot_ok is 0 for every slot of that frame. The payloads are still delivered.
- R6: When the frame-valid bit is 1, slot_ok on each slot strobe equals that slot's tag flag.
- R7: frame_done is high for exactly one bit clock, after the edge that samples frame bit 255 (the last bit of slot 12). This is the same cycle as the slot 12 strobe.
- R8: If sync rises at any in-frame edge other than the one that samples bit 255, sync_err pulses for one bit clock and frame_done does not pulse. The bit on that edge is discarded, and a new frame starts at that edge.
- R9: If sync does not rise on the edge that samples bit 255, frame_done still pulses, and sync_err pulses in the same cycle. The block then hunts and gives no slot strobe until the next sync rise.
- R10: slot_bank holds the most recent payload of each slot, with slot k at bits [20k-1:20k-20].
- R11: Back-to-back frames, in which sync rises on the edge that samples the previous frame's bit 255, raise no sync_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Link bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Frame sync line |
| sdata_in | input | 1 | Serial frame data line |
| frame_valid | output | 1 | Frame-valid bit of the current frame's tag |
| slot_tag | output | 12 | Slot valid flags, gated by frame_valid; bit k-1 is slot k |
| slot_stb | output | 1 | One-cycle pulse when a slot completes |
| slot_num | output | 4 | Number (1 to 12) of the completed slot |
| slot_data | output | 20 | Payload of the completed slot |
| slot_ok | output | 1 | Valid flag of the completed slot |
| slot_bank | output | 240 | Latest payload of every slot, slot k at [20k-1:20k-20] |
| frame_done | output | 1 | One-cycle pulse after the last bit of slot 12 |
| sync_err | output | 1 | One-cycle pulse when sync comes early or does not come |

## Verification
A bit counter that drifts moves frame_done away from the slot 12 strobe. It also produces a false sync_err on the next nominal sync edge, so the fault shows within one 256-bit frame. A wrong tag shift order shows on frame_valid and slot_tag 16 bits after the start edge. A slot counter out of step with the bit counter puts a wrong slot_num or a shifted payload on the very first slot strobe, 36 bits into the frame. The bench checks the exact cycle of the tag update, of the first slot strobe, of frame_done and of sync_err. It also checks every payload of every frame against values computed from the requirements.

// File: rtl/slotlink_pkg.sv
// Package: shared defaults and types for the slotted audio link receiver.
// Assumes: the frame layout is one tag word followed by equal-width slots.
package slotlink_pkg;

    localparam int unsigned DEF_SLOT_W    = 20;
    localparam int unsigned DEF_NUM_SLOTS = 12;
    localparam int unsigned DEF_TAG_W     = 16;

    // Alignment state of the frame tracker.
    typedef enum logic {
        ALN_HUNT  = 1'b0,
        ALN_FRAME = 1'b1
    } align_state_t;

endpackage

// File: rtl/slotlink_align.sv
// Module: frame alignment and bit counting.
// Finds a sync rising edge (high now, low at the previous falling edge).
// Counts the frame bits that follow it and checks where the next rise lands.
// Assumes: clk is the link bit clock and every flop updates on its falling
// edge, so both input lines have been stable for half a bit time.
module slotlink_align
    import slotlink_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 256,
    parameter int unsigned IDX_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    output logic             capture,
    output logic             start,
    output logic [IDX_W-1:0] bit_idx,
    output logic             frame_done,
    output logic             sync_err
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    align_state_t state;
    logic         sync_q;
    logic         rise;
    logic         at_last;
    logic         early;
    logic         late;

    // Classify the current edge: sync rise, last bit, early or late sync.
    always_comb begin
        rise    = sync_in & ~sync_q;
        at_last = (state == ALN_FRAME) && (bit_idx == LAST_IDX);
        early   = (state == ALN_FRAME) && rise && !at_last;
        late    = at_last && !rise;
        capture = (state == ALN_FRAME) && !early;
        start   = rise;
    end

    // Track alignment, advance the bit index and raise the frame strobes.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            state      <= ALN_HUNT;
            bit_idx    <= '0;
            sync_q     <= 1'b1;
            frame_done <= 1'b0;
            sync_err   <= 1'b0;
        end else begin
            sync_q     <= sync_in;
            frame_done <= at_last;
            sync_err   <= early | late;
            if (rise) begin
                state   <= ALN_FRAME;
                bit_idx <= '0;
            end else if (late) begin
                state   <= ALN_HUNT;
                bit_idx <= '0;
            end else if (state == ALN_FRAME) begin
                bit_idx <= bit_idx + IDX_W'(1);
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(negedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R7

    AST_ERR_SINGLE: assert property (@(negedge clk) disable iff (!rst_n)
        sync_err |=> !sync_err); // R8

endmodule

// File: rtl/slotlink_tag.sv
// Module: tag capture.
// Shifts in the first TAG_W bits of each frame, MSB first. When the last tag
// bit arrives it publishes the frame-valid bit and the per-slot valid flags.
// The flags are forced to zero when the frame is not valid.
// Assumes: NUM_SLOTS is at most TAG_W-1; tag bits below the flags are unused.
module slotlink_tag #(
    parameter int unsigned TAG_W     = 16,
    parameter int unsigned NUM_SLOTS = 12,
    parameter int unsigned IDX_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic [IDX_W-1:0]     bit_idx,
    input  logic                 sdata,
    output logic                 frame_valid,
    output logic [NUM_SLOTS-1:0] slot_tag
);

    localparam logic [IDX_W-1:0] TAG_END = IDX_W'(TAG_W - 1);

    logic [TAG_W-2:0]     tag_sr;
    logic [TAG_W-1:0]     tag_next;
    logic [NUM_SLOTS-1:0] flags;
    logic                 in_tag;

    // Form the tag word as it will look with the bit now on the line.
    always_comb begin
        tag_next = {tag_sr, sdata};
        in_tag   = bit_idx < IDX_W'(TAG_W);
    end

    // Flag k (slot k+1) sits just below the frame-valid bit, in slot order.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_flag
        assign flags[g] = tag_next[TAG_W-2-g];
    end

    // Shift tag bits and publish the fields on the last tag bit.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            tag_sr      <= '0;
            frame_valid <= 1'b0;
            slot_tag    <= '0;
        end else if (capture && in_tag) begin
            tag_sr <= tag_next[TAG_W-2:0];
            if (bit_idx == TAG_END) begin
                frame_valid <= tag_next[TAG_W-1];
                slot_tag    <= flags & {NUM_SLOTS{tag_next[TAG_W-1]}};
            end
        end
    end

    AST_TAG_HELD: assert property (@(negedge clk) disable iff (!rst_n)
        (capture && !in_tag) |=> ($stable(slot_tag) && $stable(frame_valid))); // R3

endmodule

// File: rtl/slotlink_demux.sv
// Module: slot demultiplexer.
// Assembles each SLOT_W-bit slot MSB first after the tag. When a slot
// completes it pulses a strobe with the slot number, payload and valid flag,
// and writes the payload into that slot's entry of the bank.
// Assumes: start resets the slot position; capture is never high for more
// than NUM_SLOTS*SLOT_W data bits between two starts.
module slotlink_demux #(
    parameter int unsigned SLOT_W    = 20,
    parameter int unsigned NUM_SLOTS = 12,
    parameter int unsigned TAG_W     = 16,
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned NUM_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        capture,
    input  logic                        start,
    input  logic [IDX_W-1:0]            bit_idx,
    input  logic                        sdata,
    input  logic [NUM_SLOTS-1:0]        slot_tag,
    output logic                        slot_stb,
    output logic [NUM_W-1:0]            slot_num,
    output logic [SLOT_W-1:0]           slot_data,
    output logic                        slot_ok,
    output logic [NUM_SLOTS*SLOT_W-1:0] slot_bank
);

    localparam int unsigned CNT_W = $clog2(SLOT_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_W - 1);

    logic [SLOT_W-2:0] shreg;
    logic [SLOT_W-1:0] word_next;
    logic [CNT_W-1:0]  bit_cnt;
    logic [NUM_W-1:0]  slot_cnt;
    logic              in_data;
    logic              slot_end;

    // Payload word with the current bit appended, and the slot-end test.
    always_comb begin
        word_next = {shreg, sdata};
        in_data   = bit_idx >= IDX_W'(TAG_W);
        slot_end  = capture && in_data && (bit_cnt == CNT_LAST);
    end

    // Shift data bits and step the bit and slot positions.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            slot_cnt <= '0;
        end else begin
            if (capture && in_data) begin
                shreg <= word_next[SLOT_W-2:0];
                if (bit_cnt == CNT_LAST) begin
                    bit_cnt  <= '0;
                    slot_cnt <= slot_cnt + NUM_W'(1);
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
            if (start) begin
                bit_cnt  <= '0;
                slot_cnt <= '0;
            end
        end
    end

    // Present a completed slot on the strobe outputs.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            slot_stb  <= 1'b0;
            slot_num  <= '0;
            slot_data <= '0;
            slot_ok   <= 1'b0;
        end else begin
            slot_stb <= slot_end;
            if (slot_end) begin
                slot_num  <= slot_cnt + NUM_W'(1);
                slot_data <= word_next;
                slot_ok   <= slot_tag[slot_cnt];
            end
        end
    end

    // One bank entry per slot, written when that slot completes.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_bank
        logic [SLOT_W-1:0] entry_q;

        // Hold the latest payload of slot g+1.
        always_ff @(negedge clk) begin
            if (!rst_n) begin
                entry_q <= '0;
            end else if (slot_end && (slot_cnt == NUM_W'(g))) begin
                entry_q <= word_next;
            end
        end

        assign slot_bank[g*SLOT_W +: SLOT_W] = entry_q;
    end

    AST_STB_SPACED: assert property (@(negedge clk) disable iff (!rst_n)
        slot_stb |=> !slot_stb); // R4

endmodule

// File: rtl/slotlink_frame_rx.sv
// Module: slotted audio link frame receiver (top).
// Joins the alignment tracker, the tag capture and the slot demultiplexer.
// All of them sample the sync and data lines on falling bit-clock edges.
// Assumes: bit_clk is the free-running link bit clock and rst_n is
// synchronous to its falling edge.
module slotlink_frame_rx
    import slotlink_pkg::*;
#(
    parameter int unsigned SLOT_W    = DEF_SLOT_W,
    parameter int unsigned NUM_SLOTS = DEF_NUM_SLOTS,
    parameter int unsigned TAG_W     = DEF_TAG_W,
    localparam int unsigned FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W,
    localparam int unsigned IDX_W      = $clog2(FRAME_BITS),
    localparam int unsigned NUM_W      = $clog2(NUM_SLOTS + 1),
    localparam int unsigned BANK_W     = NUM_SLOTS * SLOT_W
) (
    input  logic                 bit_clk,
    input  logic                 rst_n,
    input  logic                 sync_in,
    input  logic                 sdata_in,
    output logic                 frame_valid,
    output logic [NUM_SLOTS-1:0] slot_tag,
    output logic                 slot_stb,
    output logic [NUM_W-1:0]     slot_num,
    output logic [SLOT_W-1:0]    slot_data,
    output logic                 slot_ok,
    output logic [BANK_W-1:0]    slot_bank,
    output logic                 frame_done,
    output logic                 sync_err
);

    logic             capture;
    logic             start;
    logic [IDX_W-1:0] bit_idx;

    slotlink_align #(
        .FRAME_BITS (FRAME_BITS),
        .IDX_W      (IDX_W)
    ) u_align (
        .clk        (bit_clk),
        .rst_n      (rst_n),
        .sync_in    (sync_in),
        .capture    (capture),
        .start      (start),
        .bit_idx    (bit_idx),
        .frame_done (frame_done),
        .sync_err   (sync_err)
    );

    slotlink_tag #(
        .TAG_W     (TAG_W),
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W)
    ) u_tag (
        .clk         (bit_clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .bit_idx     (bit_idx),
        .sdata       (sdata_in),
        .frame_valid (frame_valid),
        .slot_tag    (slot_tag)
    );

    slotlink_demux #(
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS),
        .TAG_W     (TAG_W),
        .IDX_W     (IDX_W),
        .NUM_W     (NUM_W)
    ) u_demux (
        .clk       (bit_clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .start     (start),
        .bit_idx   (bit_idx),
        .sdata     (sdata_in),
        .slot_tag  (slot_tag),
        .slot_stb  (slot_stb),
        .slot_num  (slot_num),
        .slot_data (slot_data),
        .slot_ok   (slot_ok),
        .slot_bank (slot_bank)
    );

    AST_DONE_WITH_LAST: assert property (@(negedge bit_clk) disable iff (!rst_n)
        frame_done |-> (slot_stb && (slot_num == NUM_W'(NUM_SLOTS)))); // R7

    AST_OK_NEEDS_VALID: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (slot_stb && !frame_valid) |-> !slot_ok); // R5

endmodule

// File: tb/slotlink_frame_rx_bench.sv
`timescale 1ns/1ps
module slotlink_frame_rx_bench;

    localparam int SW = 20;
    localparam int NS = 12;

    typedef struct packed {
        logic [15:0] tag;
        logic [19:0] seed;
        logic        fv;
        logic [11:0] mask;
    } vec_t;

    // Stimulus tag and payload seed, with the expected frame-valid and flags.
    localparam vec_t VECS [5] = '{
        '{tag: 16'hFFF8, seed: 20'hA5A5A, fv: 1'b1, mask: 12'hFFF},
        '{tag: 16'h9800, seed: 20'h12345, fv: 1'b1, mask: 12'h00C},
        '{tag: 16'h7FFF, seed: 20'hFFFFF, fv: 1'b0, mask: 12'h000},
        '{tag: 16'hC007, seed: 20'h00000, fv: 1'b1, mask: 12'h001},
        '{tag: 16'h8008, seed: 20'h5C3E1, fv: 1'b1, mask: 12'h800}
    };

    logic bit_clk = 1'b0;
    always #4 bit_clk = ~bit_clk;

    logic             rst_n;
    logic             sync_in;
    logic             sdata_in;
    logic             frame_valid;
    logic [NS-1:0]    slot_tag;
    logic             slot_stb;
    logic [3:0]       slot_num;
    logic [SW-1:0]    slot_data;
    logic             slot_ok;
    logic [NS*SW-1:0] slot_bank;
    logic             frame_done;
    logic             sync_err;

    slotlink_frame_rx u_slotlink_frame_rx (
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .sync_in     (sync_in),
        .sdata_in    (sdata_in),
        .frame_valid (frame_valid),
        .slot_tag    (slot_tag),
        .slot_stb    (slot_stb),
        .slot_num    (slot_num),
        .slot_data   (slot_data),
        .slot_ok     (slot_ok),
        .slot_bank   (slot_bank),
        .frame_done  (frame_done),
        .sync_err    (sync_err)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] pay(input logic [19:0] s, input int k);
        return s ^ (20'(k) * 20'h0B07D);
    endfunction

    // Monitor: record slot strobes, and snapshot a frame on frame_done.
    logic [19:0]      rec_data [NS];
    logic [11:0]      rec_ok;
    logic [19:0]      fin_data [NS];
    logic [11:0]      fin_ok;
    logic [11:0]      fin_tag;
    logic             fin_fv;
    logic [NS*SW-1:0] fin_bank;
    int stb_cnt = 0, done_cnt = 0, err_cnt = 0, order_bad = 0;
    int last_num = 0;

    always @(posedge bit_clk) begin
        if (rst_n === 1'b1) begin
            if (slot_stb) begin
                int n;
                n = int'(slot_num);
                stb_cnt++;
                if (!(n == 1 || n == last_num + 1) || n < 1 || n > NS) order_bad++;
                else begin
                    rec_data[n-1] = slot_data;
                    rec_ok[n-1]   = slot_ok;
                end
                last_num = n;
            end
            if (frame_done) begin
                done_cnt++;
                for (int k = 0; k < NS; k++) fin_data[k] = rec_data[k];
                fin_ok   = rec_ok;
                fin_tag  = slot_tag;
                fin_fv   = frame_valid;
                fin_bank = slot_bank;
            end
            if (sync_err) err_cnt++;
        end
    end

    // Expectations for the frame whose completion is still pending.
    bit          pend = 0;
    bit          expect_early = 0;
    logic [19:0] exp_seed;
    logic        exp_fv;
    logic [11:0] exp_mask;
    int          exp_done = 0;
    int          exp_err  = 0;
    string       pend_err_req = "R11";

    task automatic drive(input logic s, input logic d);
        @(posedge bit_clk);
        sync_in  <= s;
        sdata_in <= d;
    endtask

    task automatic check_frame();
        chk("R3", 32'(fin_fv), 32'(exp_fv));
        chk(exp_fv ? "R6" : "R5", 32'(fin_tag), 32'(exp_mask));
        for (int k = 0; k < NS; k++) begin
            chk("R4", 32'(fin_data[k]), 32'(pay(exp_seed, k + 1)));
            chk(exp_fv ? "R6" : "R5", 32'(fin_ok[k]), 32'(exp_mask[k]));
            chk("R10", 32'(fin_bank[k*SW +: SW]), 32'(pay(exp_seed, k + 1)));
        end
        chk("R7", 32'(done_cnt), 32'(exp_done));
        chk(pend_err_req, 32'(err_cnt), 32'(exp_err));
        chk("R4", 32'(order_bad), 32'd0);
    endtask

    // Send one frame of len bits; next_rise raises sync with its last bit.
    task automatic run_frame(input logic [15:0] tag, input logic [19:0] seed,
                             input logic [11:0] mask, input int len, input bit next_rise);
        for (int i = 0; i < len; i++) begin
            logic b;
            logic s;
            if (i < 16) b = tag[15-i];
            else begin
                logic [19:0] w;
                w = pay(seed, (i - 16) / SW + 1);
                b = w[SW-1-((i - 16) % SW)];
            end
            s = (i <= 14) || (next_rise && i == len - 1);
            drive(s, b);
            if (i == 0 && pend) begin
                chk("R7", 32'(frame_done), 32'd1);
                chk("R11", 32'(sync_err), 32'd0);
            end
            if (i == 0 && expect_early) begin
                chk("R8", 32'(sync_err), 32'd1);
                chk("R8", 32'(frame_done), 32'd0);
                expect_early = 0;
            end
            if (i == 1 && pend) begin
                chk("R7", 32'(frame_done), 32'd0);
                check_frame();
                pend = 0;
            end
            if (i == 16) begin
                chk("R3", 32'(frame_valid), 32'(tag[15]));
                chk("R3", 32'(slot_tag), 32'(mask));
            end
            if (i == 36) chk("R4", {27'd0, slot_stb, slot_num}, {27'd0, 1'b1, 4'd1});
            if (i == 37) chk("R4", 32'(slot_stb), 32'd0);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        sync_in  = 1'b1;
        sdata_in = 1'b0;
        for (int i = 0; i < 4; i++) drive(1'b1, 1'(i));
        @(posedge bit_clk);
        // R1: reset state of every output.
        chk("R1", {29'd0, frame_valid, slot_stb, slot_ok}, 32'd0);
        chk("R1", {30'd0, frame_done, sync_err}, 32'd0);
        chk("R1", 32'(slot_tag), 32'd0);
        chk("R1", 32'(slot_data), 32'd0);
        chk("R1", 32'(slot_bank != '0), 32'd0);
        rst_n <= 1'b1;
        // R2: sync held high out of reset starts no frame.
        for (int i = 0; i < 30; i++) drive(1'b1, 1'(i));
        chk("R2", 32'(stb_cnt + done_cnt + err_cnt), 32'd0);
        // R1: hunting with sync low gives no output.
        for (int i = 0; i < 20; i++) drive(1'b0, 1'(i));
        chk("R1", 32'(stb_cnt + done_cnt + err_cnt), 32'd0);

        // Table of back-to-back frames.
        drive(1'b1, 1'b0);
        for (int v = 0; v < 5; v++) begin
            run_frame(VECS[v].tag, VECS[v].seed, VECS[v].mask, 256, v != 4);
            exp_seed = VECS[v].seed;
            exp_fv   = VECS[v].fv;
            exp_mask = VECS[v].mask;
            exp_done = v + 1;
            exp_err  = (v == 4) ? 1 : 0;
            pend_err_req = (v == 4) ? "R9" : "R11";
            pend = (v != 4);
        end
        // R9: no sync after the last frame.
        for (int j = 0; j < 62; j++) begin
            drive(1'b0, 1'(j));
            if (j == 0) begin
                chk("R9", 32'(frame_done), 32'd1);
                chk("R9", 32'(sync_err), 32'd1);
            end
            if (j == 1) check_frame();
        end
        chk("R9", 32'(stb_cnt), 32'(5 * NS));
        chk("R9", 32'(done_cnt), 32'd5);

        // R8: early sync, then a realigned full frame.
        drive(1'b1, 1'b0);
        run_frame(16'hFFF8, 20'h0F0F0, 12'hFFF, 100, 1'b1);
        expect_early = 1;
        run_frame(16'hA000, 20'h3C3C3, 12'h002, 256, 1'b0);
        chk("R8", 32'(err_cnt), 32'd2);
        chk("R8", 32'(done_cnt), 32'd5);
        chk("R8", 32'(stb_cnt), 32'(5 * NS + 4 + 11));
        exp_seed = 20'h3C3C3;
        exp_fv   = 1'b1;
        exp_mask = 12'h002;
        exp_done = 6;
        exp_err  = 3;
        pend_err_req = "R8";
        for (int j = 0; j < 4; j++) begin
            drive(1'b0, 1'b0);
            if (j == 1) check_frame();
        end
        finish_run();
    end

endmodule